// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in a word-addressed memory. A request carries the virtual address and the kind of access (data read, data write or instruction fetch). The walker reads the top-level entry, follows it to a second-level table, reads the leaf entry and checks the access against that entry's permission bits. It then answers with a physical address or a fault code.

On a successful translation the walker keeps the leaf entry's usage bits up to date in hardware. It marks the page as referenced on every access and as modified on every write. It writes the entry back to memory only when one of those bits actually changes. Requests and responses each use a valid/ready handshake. The memory side is a single request port with a grant signal, and read data returns later with its own valid strobe.

Top module: `page_walker`

## Requirements
- R1: The top-level entry is read from word address {root_frame, vaddr[31:22]}; the 20-bit root_frame is sampled when the request is accepted.
- R2: A present top-level entry (bit 0 set) supplies the table frame in bits 31:12, and the leaf entry is read from word address {frame, vaddr[21:12]}. A successful walk makes exactly two reads.
- R3: On success rsp_fault is 0 and rsp_paddr is {leaf bits 31:12, vaddr[11:0]}.
- R4: A top-level entry with bit 0 clear ends the walk after one read with rsp_fault = 1. Nothing is written.
- R5: A leaf entry with bit 0 clear gives rsp_fault = 2. Nothing is written.
- R6: Access code 0 (read) needs leaf bit 1, code 1 (write) needs bit 2 and code 2 (execute) needs bit 3. Code 3 is always refused. A refused access gives rsp_fault = 3.
- R7: A successful access sets leaf bit 4 (referenced). A successful write also sets leaf bit 5 (modified). The updated entry is written to the leaf's own address.
- R8: When the referenced bit, and for writes the modified bit, are already set, no write is issued.
- R9: req_ready is high only when the walker is idle. A response stays valid, with paddr and fault unchanged, until rsp_ready is seen.
- R10: A faulting translation leaves the leaf entry in memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_frame | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | 32 | Physical address |
| rsp_fault | output | 2 | 0 ok, 1 top missing, 2 leaf missing, 3 permission |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A corrupted table frame or latched address shows on the first or second read address, and so on the memory port within a cycle or two of acceptance. It also shows as a wrong rsp_paddr when the response appears. A stale leaf copy or a wrong access kind shows as a wrong fault code, a missing or needless write-back, or a written entry whose usage bits are wrong. The bench inspects its memory model right after each response to catch these. Holding back rsp_ready and stalling the grant expose any state that moves while the walker should be waiting.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // entry control bit positions
  localparam int E_PRESENT = 0;
  localparam int E_RD      = 1;
  localparam int E_WR      = 2;
  localparam int E_EX      = 3;
  localparam int E_REF     = 4;
  localparam int E_MOD     = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_TOP  = 2'd1,
    FLT_LEAF = 2'd2,
    FLT_PERM = 2'd3
  } fault_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOP_REQ,
    ST_TOP_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_EVAL,
    ST_WB,
    ST_RESP
  } walk_st_t;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int FRAME_W = VA_W - OFF_W,
  localparam int WADDR_W = FRAME_W + IDX_W
) (
  input  logic               sel_leaf,
  input  logic [VA_W-1:0]    va,
  input  logic [FRAME_W-1:0] root,
  input  logic [FRAME_W-1:0] tbl,
  output logic [WADDR_W-1:0] waddr
);
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] leaf_idx;

  assign top_idx  = va[VA_W-1 -: IDX_W];
  assign leaf_idx = va[OFF_W +: IDX_W];

  always_comb begin
    if (sel_leaf) waddr = {tbl, leaf_idx};
    else          waddr = {root, top_idx};
  end
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] leaf,
  input  logic [1:0]       acc,
  output logic [1:0]       fault,
  output logic [PTE_W-1:0] upd,
  output logic             need_wb
);
  logic allowed;

  always_comb begin
    unique case (acc_t'(acc))
      ACC_READ:  allowed = leaf[E_RD];
      ACC_WRITE: allowed = leaf[E_WR];
      ACC_EXEC:  allowed = leaf[E_EX];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!leaf[E_PRESENT])  fault = FLT_LEAF;
    else if (!allowed)     fault = FLT_PERM;
    else                   fault = FLT_NONE;
  end

  always_comb begin
    upd = leaf;
    upd[E_REF] = 1'b1;
    if (acc_t'(acc) == ACC_WRITE) upd[E_MOD] = 1'b1;
  end

  assign need_wb = (fault == FLT_NONE) && (upd != leaf);
endmodule

// File: rtl/pw_walk_ctrl.sv
module pw_walk_ctrl
  import pw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int FRAME_W = VA_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [VA_W-1:0]    mem_rdata,
  output logic               sel_leaf,
  output logic [VA_W-1:0]    va_q,
  output logic [FRAME_W-1:0] root_q,
  output logic [FRAME_W-1:0] tbl_q,
  output logic [VA_W-1:0]    leaf_q,
  output logic [1:0]         acc_q,
  input  logic [1:0]         chk_fault,
  input  logic [VA_W-1:0]    chk_upd,
  input  logic               chk_need_wb
);
  walk_st_t          st;
  logic [VA_W-1:0]   paddr_q;
  logic [1:0]        fault_q;
  logic [VA_W-1:0]   upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      leaf_q  <= '0;
      acc_q   <= '0;
      paddr_q <= '0;
      fault_q <= '0;
      upd_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          root_q <= root_frame;
          st     <= ST_TOP_REQ;
        end
        ST_TOP_REQ:  if (mem_gnt) st <= ST_TOP_WAIT;
        ST_TOP_WAIT: if (mem_rvalid) begin
          if (mem_rdata[E_PRESENT]) begin
            tbl_q <= mem_rdata[VA_W-1:OFF_W];
            st    <= ST_LEAF_REQ;
          end else begin
            fault_q <= FLT_TOP;
            paddr_q <= '0;
            st      <= ST_RESP;
          end
        end
        ST_LEAF_REQ:  if (mem_gnt) st <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: if (mem_rvalid) begin
          leaf_q <= mem_rdata;
          st     <= ST_EVAL;
        end
        ST_EVAL: begin
          fault_q <= chk_fault;
          upd_q   <= chk_upd;
          paddr_q <= (chk_fault == FLT_NONE) ?
                     {leaf_q[VA_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
          st      <= chk_need_wb ? ST_WB : ST_RESP;
        end
        ST_WB:   if (mem_gnt) st <= ST_RESP;
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
  assign mem_req   = (st == ST_TOP_REQ) || (st == ST_LEAF_REQ) || (st == ST_WB);
  assign mem_we    = (st == ST_WB);
  assign mem_wdata = upd_q;
  assign sel_leaf  = (st != ST_TOP_REQ);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_wb_marks_ref_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[E_REF] && mem_wdata[E_PRESENT]);

  assert_wb_changes_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata != leaf_q);

  assert_wb_only_ok_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> chk_fault == FLT_NONE);

  assert_perm_granted_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == FLT_NONE |->
      (acc_q == ACC_READ  && leaf_q[E_RD]) ||
      (acc_q == ACC_WRITE && leaf_q[E_WR]) ||
      (acc_q == ACC_EXEC  && leaf_q[E_EX]));
endmodule

// File: rtl/page_walker.sv
module page_walker #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int FRAME_W = VA_W - OFF_W,
  localparam int WADDR_W = FRAME_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [VA_W-1:0]    mem_rdata
);
  logic               sel_leaf;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [VA_W-1:0]    leaf_q;
  logic [1:0]         acc_q;
  logic [1:0]         chk_fault;
  logic [VA_W-1:0]    chk_upd;
  logic               chk_need_wb;

  pw_walk_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .sel_leaf(sel_leaf), .va_q(va_q), .root_q(root_q), .tbl_q(tbl_q),
    .leaf_q(leaf_q), .acc_q(acc_q),
    .chk_fault(chk_fault), .chk_upd(chk_upd), .chk_need_wb(chk_need_wb)
  );

  pw_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .sel_leaf(sel_leaf), .va(va_q), .root(root_q), .tbl(tbl_q),
    .waddr(mem_addr)
  );

  pw_entry_check #(.PTE_W(VA_W)) u_check (
    .leaf(leaf_q), .acc(acc_q),
    .fault(chk_fault), .upd(chk_upd), .need_wb(chk_need_wb)
  );
endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] root_frame = 20'h00010;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req, mem_we, mem_gnt;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  page_walker dut (
    .clk(clk), .rst(rst), .root_frame(root_frame),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] mem [logic [29:0]];
  logic        poke_en = 1'b0;
  logic [29:0] poke_addr = '0;
  logic [31:0] poke_data = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [29:0] rd_addr [2];
  logic        stall = 1'b0;
  logic [31:0] cyc = 0;
  int          n_chk = 0, n_bad = 0;

  assign mem_gnt = stall ? cyc[0] : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    if (poke_en) mem[poke_addr] = poke_data;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        if (rd_cnt < 2) rd_addr[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] peek(input logic [29:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [29:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_addr = a; poke_data = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_va(input int l1, input int l2, input int off);
    return {l1[9:0], l2[9:0], off[11:0]};
  endfunction

  logic [31:0] got_paddr;
  logic [1:0]  got_fault;
  int          got_rd, got_wr;

  // hold: cycles to keep rsp_ready low once response is seen
  task automatic xlate(input logic [31:0] va, input logic [1:0] acc, input int hold);
    int r0, w0;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !rsp_valid; i++) begin
      if (!rsp_valid) check("R9 busy req_ready", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    got_paddr = rsp_paddr; got_fault = rsp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R9 rsp_valid held", {31'b0, rsp_valid}, 32'h1);
      check("R9 paddr stable", rsp_paddr, got_paddr);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 idle after rsp", {31'b0, req_ready}, 32'h1);
    got_rd = rd_cnt - r0; got_wr = wr_cnt - w0;
  endtask

  localparam logic [19:0] TBL = 20'h00020;
  localparam logic [19:0] LFR = 20'hABCDE;
  function automatic logic [29:0] top_a(input int l1);
    return {20'h00010, l1[9:0]};
  endfunction
  function automatic logic [29:0] leaf_a(input int l2);
    return {TBL, l2[9:0]};
  endfunction

  task automatic t_reset;
    check("R9 reset req_ready", {31'b0, req_ready}, 32'h1);
    check("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R9 reset mem_req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_read_ok;
    poke(leaf_a(5), {LFR, 12'h003});          // P,R
    xlate(mk_va(3, 5, 12'h234), 2'd0, 0);
    check("R3 fault", {30'b0, got_fault}, 0);
    check("R3 paddr", got_paddr, {LFR, 12'h234});
    check("R2 read count", got_rd, 2);
    check("R1 top addr", {2'b0, rd_addr[0]}, {2'b0, top_a(3)});
    check("R2 leaf addr", {2'b0, rd_addr[1]}, {2'b0, leaf_a(5)});
    check("R7 ref set", peek(leaf_a(5)), {LFR, 12'h013});
    check("R7 one write", got_wr, 1);
    xlate(mk_va(3, 5, 12'hFFF), 2'd0, 0);
    check("R8 no rewrite", got_wr, 0);
    check("R3 paddr edge off", got_paddr, {LFR, 12'hFFF});
  endtask

  task automatic t_write;
    poke(leaf_a(6), {20'h12345, 12'h017});    // P,R,W,REF
    xlate(mk_va(3, 6, 12'h010), 2'd1, 0);
    check("R3 write fault", {30'b0, got_fault}, 0);
    check("R7 mod set", peek(leaf_a(6)), {20'h12345, 12'h037});
    check("R7 write wb", got_wr, 1);
    xlate(mk_va(3, 6, 12'h010), 2'd1, 0);
    check("R8 no second wb", got_wr, 0);
  endtask

  task automatic t_perm;
    poke(leaf_a(7), {20'h00777, 12'h009});    // P,X
    xlate(mk_va(3, 7, 12'h000), 2'd2, 0);
    check("R6 exec ok", {30'b0, got_fault}, 0);
    check("R7 exec ref", peek(leaf_a(7)), {20'h00777, 12'h019});
    xlate(mk_va(3, 7, 12'h000), 2'd0, 0);
    check("R6 read denied", {30'b0, got_fault}, 3);
    xlate(mk_va(3, 7, 12'h000), 2'd1, 0);
    check("R6 write denied", {30'b0, got_fault}, 3);
    check("R10 no write on fault", got_wr, 0);
    check("R10 entry kept", peek(leaf_a(7)), {20'h00777, 12'h019});
    poke(leaf_a(8), {20'h00888, 12'h00F});    // P,R,W,X
    xlate(mk_va(3, 8, 12'h000), 2'd3, 0);
    check("R6 reserved code", {30'b0, got_fault}, 3);
    check("R10 reserved keeps", peek(leaf_a(8)), {20'h00888, 12'h00F});
  endtask

  task automatic t_top_missing;
    xlate(mk_va(9, 5, 12'h000), 2'd0, 0);
    check("R4 fault", {30'b0, got_fault}, 1);
    check("R4 one read", got_rd, 1);
    check("R4 no write", got_wr, 0);
  endtask

  task automatic t_leaf_missing;
    poke(leaf_a(11), {20'h00BBB, 12'h00E});   // R,W,X but not present
    xlate(mk_va(3, 11, 12'h000), 2'd0, 0);
    check("R5 fault", {30'b0, got_fault}, 2);
    check("R5 no write", got_wr, 0);
    check("R10 leaf kept", peek(leaf_a(11)), {20'h00BBB, 12'h00E});
  endtask

  task automatic t_backpressure;
    poke(leaf_a(12), {20'h0C0C0, 12'h005});   // P,W only
    stall = 1'b1;
    xlate(mk_va(3, 12, 12'h0AB), 2'd1, 5);
    stall = 1'b0;
    check("R9 paddr after hold", got_paddr, {20'h0C0C0, 12'h0AB});
    check("R7 stalled wb", peek(leaf_a(12)), {20'h0C0C0, 12'h035});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    poke(top_a(3), {TBL, 12'h001});
    t_read_ok();
    t_write();
    t_perm();
    t_top_missing();
    t_leaf_missing();
    t_backpressure();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule